// File: doc/BRIEF.md
# Quad-Channel Wiper Command Executor

This block sits behind a two-wire serial front end and turns received command bytes into register actions for a four-channel digital potentiometer. Each channel has a wiper position, held in an external counter, and four stored settings of `DW` bits, sixteen settings in all. The front end reports start and stop conditions, each command byte and each data byte as one-cycle pulses. The block answers reads on a data port, loads the wiper counters, enables step mode on one counter, and keeps the sixteen stored settings.

Writes to the stored settings model nonvolatile programming. They are staged while the transaction runs and take effect only when the stop arrives. A busy interval of `NVW_CYCLES` clocks then follows. During that interval the front end stays silent, so the block ignores any command or data pulse that reaches it. A low write-protect level at the stop cancels the store and raises no busy interval. Wiper loads and reads take effect at once. All-channel transfers move a whole column of settings to the wipers, or all four wipers into one column.

Top module: `pot_cmd_exec`

## Requirements
- R1: The command byte is split into an operation code in bits 7:4, a stored-setting index in bits 3:2 and a channel index in bits 1:0. Each check below depends on this split.
- R2: Operation 1001 (read wiper) raises `rd_valid` for one cycle, in the cycle after the command pulse. In that cycle `rd_data` holds the wiper value of the indexed channel.
- R3: Operation 1011 (read stored) gives the stored setting at (channel, index) with the same timing as R2.
- R4: Operation 1010 (write wiper), followed by a data pulse, raises only the `wiper_load` bit of the indexed channel for one cycle after the data pulse. The channel's `wiper_data` slice carries the data in that cycle.
- R5: Operation 1101 loads the indexed channel's wiper from its stored setting in the cycle after the command pulse. Operation 0001 does the same for all four channels at once, each from its own setting at the index.
- R6: Operation 1100 (write stored, with data), operation 1110 (one wiper to a stored setting) and operation 1000 (all wipers to the indexed column) change stored settings only when a stop arrives. A start before that stop discards the staged store.
- R7: A store committed at a stop raises `busy` for exactly `NVW_CYCLES` cycles, starting the cycle after the stop. Command and data pulses that arrive while `busy` is high have no effect.
- R8: If `wp_n` is low at the stop, a staged store leaves every stored setting unchanged and `busy` stays low.
- R9: Operation 0010 sets the indexed channel's `step_en` bit from the cycle after the command until the next stop or start. At most one bit is ever set.
- R10: Any operation code outside the nine listed ones produces no read, no wiper load, no store and no busy interval.
- R11: During reset `busy`, `step_en`, `rd_valid` and `wiper_load` are low. Index 0 settings reset to `DR0_INIT` and all other settings reset to 0. In the first cycle after reset, all four wipers are loaded from their index 0 settings.
- R12: Only the low `DW` bits of a data byte are used. A data pulse that does not follow a write command is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | One-cycle pulse: a command byte was received |
| cmd_byte | input | 8 | Received command byte |
| data_valid | input | 1 | One-cycle pulse: a data byte was received |
| data_byte | input | 8 | Received data byte |
| start_seen | input | 1 | Start condition pulse |
| stop_seen | input | 1 | Stop condition pulse |
| wp_n | input | 1 | Low blocks stores to the stored settings |
| wiper_in | input | 4*DW | Current wiper values from the channel counters, channel 0 in the low bits |
| wiper_load | output | 4 | Per-channel load strobe for the counters |
| wiper_data | output | 4*DW | Load values, channel 0 in the low bits |
| step_en | output | 4 | Per-channel step-mode enable |
| rd_valid | output | 1 | Read data strobe |
| rd_data | output | DW | Read data to the front end |
| busy | output | 1 | Store interval in progress |

## Verification
The hardest state to reach is a command or data pulse that lands inside the busy window. The bench commits a store and then, while `busy` is still high, sends a read and a transfer. It expects neither `rd_valid` nor `wiper_load` to rise. The other states that are easy to miss are a staged store cancelled by a start, and a store committed with write protect low. For both, the bench reads the setting back afterwards to show that it did not change.

// File: rtl/potcmd_pkg.sv
`timescale 1ns/1ps
package potcmd_pkg;
   localparam int CH_W  = 2;
   localparam int RS_W  = 2;
   localparam int NCH   = 1 << CH_W;
   localparam int NREG  = 1 << RS_W;
   localparam int OPC_W = 4;

   localparam logic [OPC_W-1:0] OPC_RD_WIP = 4'b1001;
   localparam logic [OPC_W-1:0] OPC_WR_WIP = 4'b1010;
   localparam logic [OPC_W-1:0] OPC_RD_SET = 4'b1011;
   localparam logic [OPC_W-1:0] OPC_WR_SET = 4'b1100;
   localparam logic [OPC_W-1:0] OPC_S2W    = 4'b1101;
   localparam logic [OPC_W-1:0] OPC_W2S    = 4'b1110;
   localparam logic [OPC_W-1:0] OPC_ALL_S2W = 4'b0001;
   localparam logic [OPC_W-1:0] OPC_ALL_W2S = 4'b1000;
   localparam logic [OPC_W-1:0] OPC_STEP   = 4'b0010;

   typedef enum logic [3:0] {
      OP_NONE, OP_RD_WIP, OP_WR_WIP, OP_RD_SET, OP_WR_SET,
      OP_S2W, OP_W2S, OP_ALL_S2W, OP_ALL_W2S, OP_STEP
   } op_e;

   typedef struct packed {
      op_e             op;
      logic [RS_W-1:0] rs;
      logic [CH_W-1:0] ch;
   } cmd_t;
endpackage

// File: rtl/potcmd_decode.sv
`timescale 1ns/1ps
module potcmd_decode
   import potcmd_pkg::*;
(
   input  logic [7:0] cmd_byte_i,
   output cmd_t       cmd_o
);
   always_comb begin
      cmd_o.rs = cmd_byte_i[CH_W +: RS_W];
      cmd_o.ch = cmd_byte_i[0 +: CH_W];
      unique case (cmd_byte_i[7 -: OPC_W])
         OPC_RD_WIP:  cmd_o.op = OP_RD_WIP;
         OPC_WR_WIP:  cmd_o.op = OP_WR_WIP;
         OPC_RD_SET:  cmd_o.op = OP_RD_SET;
         OPC_WR_SET:  cmd_o.op = OP_WR_SET;
         OPC_S2W:     cmd_o.op = OP_S2W;
         OPC_W2S:     cmd_o.op = OP_W2S;
         OPC_ALL_S2W: cmd_o.op = OP_ALL_S2W;
         OPC_ALL_W2S: cmd_o.op = OP_ALL_W2S;
         OPC_STEP:    cmd_o.op = OP_STEP;
         default:     cmd_o.op = OP_NONE;
      endcase
   end
endmodule

// File: rtl/potcmd_nv_timer.sv
`timescale 1ns/1ps
module potcmd_nv_timer #(
   parameter int CYCLES = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic busy_o
);
   localparam int CW = $clog2(CYCLES + 1);

   if (CYCLES < 1) begin : g_bad_cycles
      $error("potcmd_nv_timer: CYCLES must be at least 1");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (start_i)        cnt_q <= CW'(CYCLES);
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign busy_o = (cnt_q != '0);

   // R7: the busy window only opens from a commit
   a_r7_busy_from_commit: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> $past(start_i));
   // R7: no new commit while a window is open
   a_r7_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |-> !busy_o);
endmodule

// File: rtl/potcmd_bank.sv
`timescale 1ns/1ps
module potcmd_bank
   import potcmd_pkg::*;
#(
   parameter int          DW    = 6,
   parameter int unsigned INIT0 = 0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                we_i,
   input  logic [NCH-1:0]      wmask_i,
   input  logic [RS_W-1:0]     wsel_i,
   input  logic [NCH*DW-1:0]   wdata_i,
   input  logic [CH_W-1:0]     rch_i,
   input  logic [RS_W-1:0]     rsel_i,
   output logic [DW-1:0]       rdata_o,
   input  logic [RS_W-1:0]     csel_i,
   output logic [NCH*DW-1:0]   col_o
);
   localparam int FLAT_W = NCH * NREG * DW;

   logic [DW-1:0]     mem [NCH][NREG];
   logic [FLAT_W-1:0] flat;

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      for (genvar r = 0; r < NREG; r++) begin : g_rs
         localparam logic [DW-1:0] RST_V = (r == 0) ? DW'(INIT0) : '0;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               mem[c][r] <= RST_V;
            else if (we_i && wmask_i[c] && (wsel_i == RS_W'(r)))
               mem[c][r] <= wdata_i[c*DW +: DW];
         end
         assign flat[(c*NREG + r)*DW +: DW] = mem[c][r];
      end
      assign col_o[c*DW +: DW] = mem[c][csel_i];
   end

   assign rdata_o = mem[rch_i][rsel_i];

   // R6: settings move only on a commit
   a_r6_hold_without_commit: assert property (@(posedge clk) disable iff (!rst_n)
      !we_i |=> $stable(flat));
endmodule

// File: rtl/pot_cmd_exec.sv
`timescale 1ns/1ps
module pot_cmd_exec
   import potcmd_pkg::*;
#(
   parameter int          DW         = 6,
   parameter int          NVW_CYCLES = 16,
   parameter int unsigned DR0_INIT   = 32,
   parameter bit          RD_REG     = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [7:0]        cmd_byte,
   input  logic              data_valid,
   input  logic [7:0]        data_byte,
   input  logic              start_seen,
   input  logic              stop_seen,
   input  logic              wp_n,
   input  logic [4*DW-1:0]   wiper_in,
   output logic [3:0]        wiper_load,
   output logic [4*DW-1:0]   wiper_data,
   output logic [3:0]        step_en,
   output logic              rd_valid,
   output logic [DW-1:0]     rd_data,
   output logic              busy
);
   localparam int VW = NCH * DW;

   if (DW < 1 || DW > 8) begin : g_bad_dw
      $error("pot_cmd_exec: DW must lie in 1..8");
   end
   if (DR0_INIT >= (1 << DW)) begin : g_bad_init
      $error("pot_cmd_exec: DR0_INIT does not fit in DW bits");
   end
   if (NCH != 4) begin : g_bad_nch
      $error("pot_cmd_exec: channel field must give four channels");
   end

   cmd_t             dec;
   logic             rec_done_q;
   logic             accept_cmd, accept_dat, commit;
   op_e              cur_op_q;
   logic [CH_W-1:0]  cur_ch_q;
   logic             pend_q;
   logic [NCH-1:0]   stg_mask_q;
   logic [RS_W-1:0]  stg_rs_q;
   logic [VW-1:0]    stg_val_q;
   logic [NCH-1:0]   load_q, step_q;
   logic [VW-1:0]    load_data_q;
   logic [RS_W-1:0]  col_sel;
   logic [VW-1:0]    col_rd;
   logic [DW-1:0]    set_rd;
   logic             rd_hit;
   logic [DW-1:0]    rd_src;
   logic [DW-1:0]    dat;

   potcmd_decode u_dec (
      .cmd_byte_i (cmd_byte),
      .cmd_o      (dec)
   );

   assign accept_cmd = cmd_valid  && !busy && rec_done_q;
   assign accept_dat = data_valid && !busy && rec_done_q;
   assign commit     = stop_seen && pend_q && wp_n && !busy;
   assign col_sel    = rec_done_q ? dec.rs : '0;
   assign dat        = data_byte[DW-1:0];

   potcmd_bank #(
      .DW    (DW),
      .INIT0 (DR0_INIT)
   ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (commit),
      .wmask_i (stg_mask_q),
      .wsel_i  (stg_rs_q),
      .wdata_i (stg_val_q),
      .rch_i   (dec.ch),
      .rsel_i  (dec.rs),
      .rdata_o (set_rd),
      .csel_i  (col_sel),
      .col_o   (col_rd)
   );

   potcmd_nv_timer #(
      .CYCLES (NVW_CYCLES)
   ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (commit),
      .busy_o  (busy)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rec_done_q  <= 1'b0;
         cur_op_q    <= OP_NONE;
         cur_ch_q    <= '0;
         pend_q      <= 1'b0;
         stg_mask_q  <= '0;
         stg_rs_q    <= '0;
         stg_val_q   <= '0;
         load_q      <= '0;
         load_data_q <= '0;
         step_q      <= '0;
      end else begin
         load_q     <= '0;
         rec_done_q <= 1'b1;
         if (!rec_done_q) begin
            load_q      <= '1;
            load_data_q <= col_rd;
         end
         if (start_seen || stop_seen) begin
            cur_op_q <= OP_NONE;
            pend_q   <= 1'b0;
            step_q   <= '0;
         end else if (accept_cmd) begin
            cur_op_q <= dec.op;
            cur_ch_q <= dec.ch;
            pend_q   <= 1'b0;
            step_q   <= '0;
            unique case (dec.op)
               OP_S2W: begin
                  load_q[dec.ch] <= 1'b1;
                  load_data_q[int'(dec.ch)*DW +: DW] <= col_rd[int'(dec.ch)*DW +: DW];
               end
               OP_ALL_S2W: begin
                  load_q      <= '1;
                  load_data_q <= col_rd;
               end
               OP_W2S: begin
                  stg_mask_q <= NCH'(1) << dec.ch;
                  stg_rs_q   <= dec.rs;
                  stg_val_q[int'(dec.ch)*DW +: DW] <= wiper_in[int'(dec.ch)*DW +: DW];
                  pend_q     <= 1'b1;
               end
               OP_ALL_W2S: begin
                  stg_mask_q <= '1;
                  stg_rs_q   <= dec.rs;
                  stg_val_q  <= wiper_in;
                  pend_q     <= 1'b1;
               end
               OP_WR_SET: stg_rs_q <= dec.rs;
               OP_STEP:   step_q[dec.ch] <= 1'b1;
               default: ;
            endcase
         end else if (accept_dat) begin
            if (cur_op_q == OP_WR_WIP) begin
               load_q[cur_ch_q] <= 1'b1;
               load_data_q[int'(cur_ch_q)*DW +: DW] <= dat;
            end
            if (cur_op_q == OP_WR_SET) begin
               stg_mask_q <= NCH'(1) << cur_ch_q;
               stg_val_q[int'(cur_ch_q)*DW +: DW] <= dat;
               pend_q     <= 1'b1;
            end
            cur_op_q <= OP_NONE;
         end
      end
   end

   assign wiper_load = load_q;
   assign wiper_data = load_data_q;
   assign step_en    = step_q;

   assign rd_hit = accept_cmd && ((dec.op == OP_RD_WIP) || (dec.op == OP_RD_SET));
   assign rd_src = (dec.op == OP_RD_WIP) ? wiper_in[int'(dec.ch)*DW +: DW] : set_rd;

   if (RD_REG) begin : g_rd_reg
      logic          rd_valid_q;
      logic [DW-1:0] rd_data_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rd_valid_q <= 1'b0;
            rd_data_q  <= '0;
         end else begin
            rd_valid_q <= rd_hit;
            if (rd_hit) rd_data_q <= rd_src;
         end
      end
      assign rd_valid = rd_valid_q;
      assign rd_data  = rd_data_q;

      // R7: a read arriving in the busy window is dropped
      a_r7_busy_drops_read: assert property (@(posedge clk) disable iff (!rst_n)
         busy && cmd_valid |=> !rd_valid);
   end else begin : g_rd_comb
      assign rd_valid = rd_hit;
      assign rd_data  = rd_src;
   end

   // R7: no wiper load follows a cycle spent busy
   a_r7_busy_no_load: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> (wiper_load == '0));
   // R8: protected stop never opens a busy window
   a_r8_protect_no_busy: assert property (@(posedge clk) disable iff (!rst_n)
      stop_seen && !wp_n && !busy |=> !busy);
   // R9: at most one channel in step mode
   a_r9_step_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(step_en));
   // R9: start or stop ends step mode
   a_r9_step_ends: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_seen || start_seen) |=> (step_en == '0));
endmodule

// File: tb/sim_pot_cmd_exec.sv
`timescale 1ns/1ps
module sim_pot_cmd_exec;
   localparam int DW    = 6;
   localparam int NVW   = 8;
   localparam int INIT0 = 21;
   localparam int NT    = 17;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            cmd_valid = 1'b0, data_valid = 1'b0;
   logic [7:0]      cmd_byte = '0, data_byte = '0;
   logic            start_seen = 1'b0, stop_seen = 1'b0, wp_n = 1'b1;
   logic [4*DW-1:0] wiper_in;
   logic [3:0]      wiper_load, step_en;
   logic [4*DW-1:0] wiper_data;
   logic            rd_valid, busy;
   logic [DW-1:0]   rd_data;

   always #2.5 clk = ~clk;

   pot_cmd_exec #(.DW(DW), .NVW_CYCLES(NVW), .DR0_INIT(INIT0), .RD_REG(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
      .data_valid(data_valid), .data_byte(data_byte), .start_seen(start_seen),
      .stop_seen(stop_seen), .wp_n(wp_n), .wiper_in(wiper_in),
      .wiper_load(wiper_load), .wiper_data(wiper_data), .step_en(step_en),
      .rd_valid(rd_valid), .rd_data(rd_data), .busy(busy));

   // environment: the channel counters, loaded by the block
   logic [DW-1:0] wip [4];
   always_ff @(posedge clk or negedge rst_n) begin
      for (int i = 0; i < 4; i++) begin
         if (!rst_n) wip[i] <= '0;
         else if (wiper_load[i]) wip[i] <= wiper_data[i*DW +: DW];
      end
   end
   assign wiper_in = {wip[3], wip[2], wip[1], wip[0]};

   // reference stored settings, set from the requirements
   logic [DW-1:0] mset [4][4];

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic pulse_cmd(input logic [7:0] b);
      @(negedge clk); cmd_valid = 1'b1; cmd_byte = b;
      @(negedge clk); cmd_valid = 1'b0;
   endtask
   task automatic pulse_dat(input logic [7:0] d);
      @(negedge clk); data_valid = 1'b1; data_byte = d;
      @(negedge clk); data_valid = 1'b0;
   endtask
   task automatic pulse_stop();
      @(negedge clk); stop_seen = 1'b1;
      @(negedge clk); stop_seen = 1'b0;
   endtask
   task automatic pulse_start();
      @(negedge clk); start_seen = 1'b1;
      @(negedge clk); start_seen = 1'b0;
   endtask
   task automatic busy_len(output int n);
      n = 0;
      while (busy && n < 1000) begin n++; @(negedge clk); end
   endtask

   // {command, data, has data, expect read, expected read value}
   localparam logic [24:0] TBL [NT] = '{
      {8'hA1, 8'h2A, 1'b1, 1'b0, 7'd0},
      {8'h91, 8'h00, 1'b0, 1'b1, 7'd42},
      {8'hE9, 8'h00, 1'b0, 1'b0, 7'd0},
      {8'hB9, 8'h00, 1'b0, 1'b1, 7'd42},
      {8'hC7, 8'h0F, 1'b1, 1'b0, 7'd0},
      {8'hB7, 8'h00, 1'b0, 1'b1, 7'd15},
      {8'hD7, 8'h00, 1'b0, 1'b0, 7'd0},
      {8'h93, 8'h00, 1'b0, 1'b1, 7'd15},
      {8'h88, 8'h00, 1'b0, 1'b0, 7'd0},
      {8'hA0, 8'hFF, 1'b1, 1'b0, 7'd0},
      {8'h18, 8'h00, 1'b0, 1'b0, 7'd0},
      {8'hB8, 8'h00, 1'b0, 1'b1, 7'd21},
      {8'h90, 8'h00, 1'b0, 1'b1, 7'd21},
      {8'h52, 8'h00, 1'b0, 1'b0, 7'd0},
      {8'hF3, 8'h00, 1'b0, 1'b0, 7'd0},
      {8'h22, 8'h00, 1'b0, 1'b0, 7'd0},
      {8'h6E, 8'h00, 1'b0, 1'b0, 7'd0}
   };

   task automatic run_txn(input logic [7:0] cmd, input logic [7:0] dv, input bit has,
                          input bit rd_exp, input int rd_val);
      logic [3:0]    op;
      int            r, c, n;
      bit            st;
      logic [3:0]    smask;
      logic [DW-1:0] sval [4];
      op = cmd[7:4]; r = int'(cmd[3:2]); c = int'(cmd[1:0]);
      st = 1'b0; smask = '0;
      for (int i = 0; i < 4; i++) sval[i] = '0;
      pulse_cmd(cmd);
      case (op)
         4'b1001: begin check("R2 rd_valid", int'(rd_valid), 1); check("R2 rd_data", int'(rd_data), rd_val); end
         4'b1011: begin check("R3 rd_valid", int'(rd_valid), 1); check("R3 rd_data", int'(rd_data), rd_val); end
         4'b1101: begin
            check("R5 single load mask", int'(wiper_load), 1 << c);
            check("R5 single load value", int'(wiper_data[c*DW +: DW]), int'(mset[c][r]));
         end
         4'b0001: begin
            check("R5 all load mask", int'(wiper_load), 15);
            for (int i = 0; i < 4; i++)
               check("R5 all load value", int'(wiper_data[i*DW +: DW]), int'(mset[i][r]));
         end
         4'b0010: check("R9 step set", int'(step_en), 1 << c);
         4'b1110: begin st = 1'b1; smask[c] = 1'b1; sval[c] = wip[c]; end
         4'b1000: begin st = 1'b1; smask = '1; for (int i = 0; i < 4; i++) sval[i] = wip[i]; end
         4'b1010, 4'b1100: check("R1 no early action", int'(wiper_load) + int'(rd_valid), 0);
         default: check("R10 undefined quiet", int'(wiper_load) + int'(rd_valid) + int'(step_en), 0);
      endcase
      if (rd_exp && !(op == 4'b1001 || op == 4'b1011))
         check("R1 read decode", 0, 1);
      if (has) begin
         pulse_dat(dv);
         if (op == 4'b1010) begin
            check("R4 load mask", int'(wiper_load), 1 << c);
            check("R4 R12 load value", int'(wiper_data[c*DW +: DW]), int'(dv[DW-1:0]));
         end
         if (op == 4'b1100) begin st = 1'b1; smask[c] = 1'b1; sval[c] = dv[DW-1:0]; end
      end
      pulse_stop();
      check("R7 busy after stop", int'(busy), int'(st && wp_n));
      if (st && wp_n) begin
         busy_len(n);
         check("R7 busy length", n, NVW);
         for (int i = 0; i < 4; i++) if (smask[i]) mset[i][r] = sval[i];
      end
      if (op == 4'b0010) check("R9 step cleared", int'(step_en), 0);
   endtask

   initial begin
      int n;
      for (int i = 0; i < 4; i++)
         for (int j = 0; j < 4; j++) mset[i][j] = (j == 0) ? DW'(INIT0) : '0;
      repeat (3) @(negedge clk);
      check("R11 reset busy", int'(busy), 0);
      check("R11 reset step", int'(step_en), 0);
      check("R11 reset rd_valid", int'(rd_valid), 0);
      check("R11 reset load", int'(wiper_load), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R11 recall mask", int'(wiper_load), 15);
      for (int i = 0; i < 4; i++)
         check("R11 recall value", int'(wiper_data[i*DW +: DW]), INIT0);
      @(negedge clk);

      for (int k = 0; k < NT; k++)
         run_txn(TBL[k][24:17], TBL[k][16:9], TBL[k][8], TBL[k][7], int'(TBL[k][6:0]));

      // R8: protected store
      wp_n = 1'b0;
      run_txn(8'hC5, 8'h09, 1'b1, 1'b0, 0);
      wp_n = 1'b1;
      run_txn(8'hB5, 8'h00, 1'b0, 1'b1, 0);

      // R6: start cancels a staged store
      pulse_cmd(8'hC6); pulse_dat(8'h21); pulse_start(); pulse_stop();
      check("R6 cancelled no busy", int'(busy), 0);
      run_txn(8'hB6, 8'h00, 1'b0, 1'b1, 0);

      // R7: pulses inside the busy window
      pulse_cmd(8'hC4); pulse_dat(8'h05); pulse_stop();
      check("R7 busy open", int'(busy), 1);
      pulse_cmd(8'h90);
      check("R7 read dropped", int'(rd_valid), 0);
      pulse_cmd(8'hD4);
      check("R7 transfer dropped", int'(wiper_load), 0);
      pulse_dat(8'h11);
      check("R7 data dropped", int'(wiper_load), 0);
      busy_len(n);
      mset[0][1] = 6'd5;
      run_txn(8'hB4, 8'h00, 1'b0, 1'b1, 5);

      // R12: stray data pulse
      pulse_dat(8'h07);
      check("R12 stray data no load", int'(wiper_load), 0);
      pulse_stop();
      check("R12 stray data no busy", int'(busy), 0);

      // R9: start ends step mode
      pulse_cmd(8'h21);
      check("R9 step ch1", int'(step_en), 2);
      pulse_start();
      check("R9 step cleared by start", int'(step_en), 0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule